// File: doc/BRIEF.md
# Clock Calendar Snapshot Sequencer

This block drives a battery-backed clock/calendar device through a serial register master that sits below it. The master moves one transaction at a time: a single-bit read, a register write, a register read, or an address-only command. The sequencer runs the device-level operations on top of it.

After reset it aligns the serial link by issuing a run of single-bit reads. It then checks that the device is present by writing a scratch value to the seconds register and reading it back. If the check passes, it clears the device's status register, which switches off the measurement, test and lock modes. From then on the host can do two things. It can request a read of the time: the sequencer freezes a copy of the running clock into the device's holding registers and reads the seven calendar fields back. It can also request a set of the time: the sequencer writes the seven fields and commits them to the running clock.

All device registers hold packed BCD. On the host side the fields are binary. Month is counted from zero on the host side. The host year is an offset from 1900, and the device holds only its last two decimal digits. Read and set requests, and the returned time, use valid/ready handshakes. The present and fault flags are plain levels. All register addresses are parameters.

Top module: `clk_cal_seq`

## Requirements
- R1: After reset the block issues exactly RESYNC_BITS (default 8) single-bit read transactions before any other transaction. The transaction kind code on xfer_kind_o is 0 for a single-bit read, 1 for a register write, 2 for a register read and 3 for an address-only command.
- R2: After the resync the block writes PROBE_VAL (default 0x33) to the seconds address and reads that address back. If the value read back differs, dev_fault_o rises and stays high until reset, and no further transaction is issued.
- R3: If the probe matches, the block writes 0x00 to the status address. When that write completes, dev_ok_o rises and stays high until reset.
- R4: An accepted read request issues a command at the snapshot address. It then issues register reads at the seconds, minutes, hours, day-of-month, month, weekday and year addresses, in that order.
- R5: An accepted set request issues register writes in that same field order, then a command at the commit address. Each value is packed BCD with the tens digit in bits [7:4]. The month is written as the host field plus 1. The year is written as the host field modulo 100.
- R6: After the seventh read, time_valid_o goes high and stays high, with every time field stable, until time_ready_i is sampled high. Each field is the register's tens digit times ten plus its units digit. The month is then reduced by 1 and the year is increased by 100.
- R7: While dev_ok_o is low (during start-up or after a fault), rd_ready_o and set_ready_o are high. Any request accepted then produces a one-cycle err_o pulse in the following cycle and starts no transaction.
- R8: xfer_req_o is a one-cycle pulse. After it, no new request is issued until xfer_done_i has been seen.
- R9: Once dev_ok_o is high, both ready outputs are low while an operation or an unread result is pending. If read and set requests are both valid in the idle state, the read is accepted first and the set waits.
- R10: dev_ok_o and dev_fault_o are never high together, and both are low at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Read-time request valid |
| rd_ready_o | output | 1 | Read-time request accepted |
| set_valid_i | input | 1 | Set-time request valid |
| set_ready_o | output | 1 | Set-time request accepted |
| set_sec_i | input | 8 | Seconds to set, binary |
| set_min_i | input | 8 | Minutes to set, binary |
| set_hour_i | input | 8 | Hours to set, binary |
| set_mday_i | input | 8 | Day of month to set, binary |
| set_mon_i | input | 8 | Month to set, zero-based |
| set_wday_i | input | 8 | Weekday to set, binary |
| set_year_i | input | 8 | Year to set, offset from 1900 |
| time_valid_o | output | 1 | Read-time result valid |
| time_ready_i | input | 1 | Read-time result taken |
| tm_sec_o | output | 8 | Seconds read, binary |
| tm_min_o | output | 8 | Minutes read, binary |
| tm_hour_o | output | 8 | Hours read, binary |
| tm_mday_o | output | 8 | Day of month read, binary |
| tm_mon_o | output | 8 | Month read, zero-based |
| tm_wday_o | output | 8 | Weekday read, binary |
| tm_year_o | output | 8 | Year read, offset from 1900 |
| dev_ok_o | output | 1 | Device checked and ready |
| dev_fault_o | output | 1 | Presence check failed |
| err_o | output | 1 | Pulse: request rejected |
| xfer_req_o | output | 1 | Pulse: start a serial transaction |
| xfer_kind_o | output | 2 | Transaction kind (see R1) |
| xfer_addr_o | output | ADDR_W | Register or command address |
| xfer_wdata_o | output | 8 | Write data |
| xfer_done_i | input | 1 | Serial transaction finished |
| xfer_rdata_i | input | 8 | Read data, valid with xfer_done_i |

## Verification
The checker watches a few rules on every cycle. It confirms that only one serial transaction is outstanding at a time, and that a fault silences the link and never lifts. It confirms that the present and fault flags stay exclusive and sticky, that an error pulse follows only a request accepted before the device was ready, and that the ready outputs are low while a transaction is being issued. It also holds the returned time stable while valid waits for ready.

The transaction order, addresses and BCD encoding (month offset, year modulo 100, the +100 on read) can only be shown by the bench's scenarios. So can the read-over-set priority and the failed-probe path. The bench compares every transaction against a queue of expected ones.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int FIELD_CNT = 7;
  localparam int IDX_W     = 3;

  // Field positions, in device transfer order
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_MDAY = 3;
  localparam int F_MON  = 4;
  localparam int F_WDAY = 5;
  localparam int F_YEAR = 6;

  typedef enum logic [1:0] {
    XK_BIT_RD = 2'd0,
    XK_WR     = 2'd1,
    XK_RD     = 2'd2,
    XK_CMD    = 2'd3
  } xfer_kind_e;

  typedef enum logic [3:0] {
    S_RESYNC,
    S_PROBE_WR,
    S_PROBE_RD,
    S_CLR_STAT,
    S_IDLE,
    S_SNAP,
    S_RD_FLD,
    S_WR_FLD,
    S_COMMIT,
    S_RESP,
    S_FAULT
  } seq_state_e;

  function automatic logic [7:0] mod100(input logic [7:0] v);
    if (v >= 8'd200)      return v - 8'd200;
    else if (v >= 8'd100) return v - 8'd100;
    else                  return v;
  endfunction

endpackage

// File: rtl/ccs_bin2bcd.sv
// Binary 0..99 to packed BCD using a reciprocal multiply for the divide by ten.
module ccs_bin2bcd (
  input  logic [7:0] bin_i,
  output logic [7:0] bcd_o
);
  logic [15:0] prod;
  logic [3:0]  tens;
  logic [7:0]  rem;

  always_comb begin
    prod  = 16'(bin_i) * 16'd205;
    tens  = 4'(prod >> 11);
    rem   = bin_i - {1'b0, tens, 3'b000} - {3'b000, tens, 1'b0};
    bcd_o = {tens, 4'(rem)};
  end
endmodule

// File: rtl/ccs_bcd2bin.sv
// Packed BCD to binary: tens digit times ten plus units digit.
module ccs_bcd2bin (
  input  logic [7:0] bcd_i,
  output logic [7:0] bin_o
);
  always_comb begin
    bin_o = ({4'd0, bcd_i[7:4]} << 3) + ({4'd0, bcd_i[7:4]} << 1) + {4'd0, bcd_i[3:0]};
  end
endmodule

// File: rtl/ccs_field_addr.sv
// Maps a field position to its device register address.
module ccs_field_addr #(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] SEC_ADDR  = 4'd2,
  parameter logic [ADDR_W-1:0] MIN_ADDR  = 4'd3,
  parameter logic [ADDR_W-1:0] HOUR_ADDR = 4'd4,
  parameter logic [ADDR_W-1:0] MDAY_ADDR = 4'd5,
  parameter logic [ADDR_W-1:0] MON_ADDR  = 4'd6,
  parameter logic [ADDR_W-1:0] WDAY_ADDR = 4'd7,
  parameter logic [ADDR_W-1:0] YEAR_ADDR = 4'd8
) (
  input  logic [ccs_pkg::IDX_W-1:0] idx_i,
  output logic [ADDR_W-1:0]         addr_o
);
  always_comb begin
    case (idx_i)
      3'd0:    addr_o = SEC_ADDR;
      3'd1:    addr_o = MIN_ADDR;
      3'd2:    addr_o = HOUR_ADDR;
      3'd3:    addr_o = MDAY_ADDR;
      3'd4:    addr_o = MON_ADDR;
      3'd5:    addr_o = WDAY_ADDR;
      default: addr_o = YEAR_ADDR;
    endcase
  end
endmodule

// File: rtl/clk_cal_seq.sv
module clk_cal_seq
  import ccs_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                RESYNC_BITS = 8,
  parameter logic [7:0]        PROBE_VAL   = 8'h33,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 4'd0,
  parameter logic [ADDR_W-1:0] SEC_ADDR    = 4'd2,
  parameter logic [ADDR_W-1:0] MIN_ADDR    = 4'd3,
  parameter logic [ADDR_W-1:0] HOUR_ADDR   = 4'd4,
  parameter logic [ADDR_W-1:0] MDAY_ADDR   = 4'd5,
  parameter logic [ADDR_W-1:0] MON_ADDR    = 4'd6,
  parameter logic [ADDR_W-1:0] WDAY_ADDR   = 4'd7,
  parameter logic [ADDR_W-1:0] YEAR_ADDR   = 4'd8,
  parameter logic [ADDR_W-1:0] SNAP_CMD    = 4'd14,
  parameter logic [ADDR_W-1:0] COMMIT_CMD  = 4'd15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic              set_valid_i,
  output logic              set_ready_o,
  input  logic [7:0]        set_sec_i,
  input  logic [7:0]        set_min_i,
  input  logic [7:0]        set_hour_i,
  input  logic [7:0]        set_mday_i,
  input  logic [7:0]        set_mon_i,
  input  logic [7:0]        set_wday_i,
  input  logic [7:0]        set_year_i,
  output logic              time_valid_o,
  input  logic              time_ready_i,
  output logic [7:0]        tm_sec_o,
  output logic [7:0]        tm_min_o,
  output logic [7:0]        tm_hour_o,
  output logic [7:0]        tm_mday_o,
  output logic [7:0]        tm_mon_o,
  output logic [7:0]        tm_wday_o,
  output logic [7:0]        tm_year_o,
  output logic              dev_ok_o,
  output logic              dev_fault_o,
  output logic              err_o,
  output logic              xfer_req_o,
  output logic [1:0]        xfer_kind_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [7:0]        xfer_wdata_o,
  input  logic              xfer_done_i,
  input  logic [7:0]        xfer_rdata_i
);

  localparam int CNT_W = (RESYNC_BITS > 1) ? $clog2(RESYNC_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESYNC_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FIELD_CNT - 1);
  localparam logic [7:0]       STAT_CLEAR = 8'h00;

  seq_state_e       st_q;
  logic             wait_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             dev_ok_q;
  logic             err_q;
  logic [7:0]       rd_bcd_q [FIELD_CNT];
  logic [7:0]       wr_bin_q [FIELD_CNT];

  logic [7:0]        rd_bin [FIELD_CNT];
  logic [7:0]        wr_bcd [FIELD_CNT];
  logic [7:0]        set_in [FIELD_CNT];
  logic [ADDR_W-1:0] fld_addr;
  logic              is_op;
  logic              reject;
  logic              rd_fire;
  logic              set_fire;
  xfer_kind_e        kind;

  // Host field staging: month to one-based, year to two digits
  always_comb begin
    set_in[F_SEC]  = set_sec_i;
    set_in[F_MIN]  = set_min_i;
    set_in[F_HOUR] = set_hour_i;
    set_in[F_MDAY] = set_mday_i;
    set_in[F_MON]  = set_mon_i + 8'd1;
    set_in[F_WDAY] = set_wday_i;
    set_in[F_YEAR] = mod100(set_year_i);
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_conv
    ccs_bin2bcd u_enc (.bin_i(wr_bin_q[g]), .bcd_o(wr_bcd[g]));
    ccs_bcd2bin u_dec (.bcd_i(rd_bcd_q[g]), .bin_o(rd_bin[g]));
  end

  ccs_field_addr #(
    .ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR), .MIN_ADDR(MIN_ADDR),
    .HOUR_ADDR(HOUR_ADDR), .MDAY_ADDR(MDAY_ADDR), .MON_ADDR(MON_ADDR),
    .WDAY_ADDR(WDAY_ADDR), .YEAR_ADDR(YEAR_ADDR)
  ) u_faddr (
    .idx_i (idx_q),
    .addr_o(fld_addr)
  );

  // Handshake: all requests are swallowed (and flagged) until the device is ready
  always_comb begin
    reject      = !dev_ok_q;
    rd_ready_o  = reject || (st_q == S_IDLE);
    set_ready_o = reject || ((st_q == S_IDLE) && !rd_valid_i);
    rd_fire     = rd_valid_i && rd_ready_o;
    set_fire    = set_valid_i && set_ready_o;
  end

  always_comb begin
    unique case (st_q)
      S_RESYNC, S_PROBE_WR, S_PROBE_RD, S_CLR_STAT,
      S_SNAP, S_RD_FLD, S_WR_FLD, S_COMMIT: is_op = 1'b1;
      default:                              is_op = 1'b0;
    endcase
  end

  // Transaction decode per state
  always_comb begin
    kind         = XK_BIT_RD;
    xfer_addr_o  = '0;
    xfer_wdata_o = 8'h00;
    case (st_q)
      S_PROBE_WR: begin kind = XK_WR;  xfer_addr_o = SEC_ADDR; xfer_wdata_o = PROBE_VAL; end
      S_PROBE_RD: begin kind = XK_RD;  xfer_addr_o = SEC_ADDR; end
      S_CLR_STAT: begin kind = XK_WR;  xfer_addr_o = STAT_ADDR; xfer_wdata_o = STAT_CLEAR; end
      S_SNAP:     begin kind = XK_CMD; xfer_addr_o = SNAP_CMD; end
      S_RD_FLD:   begin kind = XK_RD;  xfer_addr_o = fld_addr; end
      S_WR_FLD:   begin kind = XK_WR;  xfer_addr_o = fld_addr; xfer_wdata_o = wr_bcd[idx_q]; end
      S_COMMIT:   begin kind = XK_CMD; xfer_addr_o = COMMIT_CMD; end
      default:    ;
    endcase
    xfer_kind_o = kind;
    xfer_req_o  = is_op && !wait_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_RESYNC;
      wait_q   <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      dev_ok_q <= 1'b0;
      err_q    <= 1'b0;
      for (int i = 0; i < FIELD_CNT; i++) begin
        rd_bcd_q[i] <= 8'h00;
        wr_bin_q[i] <= 8'h00;
      end
    end else begin
      err_q <= reject && (rd_fire || set_fire);

      if (is_op) begin
        if (!wait_q) begin
          wait_q <= 1'b1;
        end else if (xfer_done_i) begin
          wait_q <= 1'b0;
          case (st_q)
            S_RESYNC: begin
              if (cnt_q == CNT_LAST) st_q <= S_PROBE_WR;
              else                   cnt_q <= cnt_q + 1'b1;
            end
            S_PROBE_WR: st_q <= S_PROBE_RD;
            S_PROBE_RD: st_q <= (xfer_rdata_i == PROBE_VAL) ? S_CLR_STAT : S_FAULT;
            S_CLR_STAT: begin
              st_q     <= S_IDLE;
              dev_ok_q <= 1'b1;
            end
            S_SNAP: begin
              st_q  <= S_RD_FLD;
              idx_q <= '0;
            end
            S_RD_FLD: begin
              rd_bcd_q[idx_q] <= xfer_rdata_i;
              if (idx_q == IDX_LAST) st_q <= S_RESP;
              else                   idx_q <= idx_q + 1'b1;
            end
            S_WR_FLD: begin
              if (idx_q == IDX_LAST) st_q <= S_COMMIT;
              else                   idx_q <= idx_q + 1'b1;
            end
            default: st_q <= S_IDLE;
          endcase
        end
      end else begin
        case (st_q)
          S_IDLE: begin
            if (rd_fire) begin
              st_q <= S_SNAP;
            end else if (set_fire) begin
              st_q  <= S_WR_FLD;
              idx_q <= '0;
              for (int i = 0; i < FIELD_CNT; i++) wr_bin_q[i] <= set_in[i];
            end
          end
          S_RESP: if (time_ready_i) st_q <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    time_valid_o = (st_q == S_RESP);
    dev_ok_o     = dev_ok_q;
    dev_fault_o  = (st_q == S_FAULT);
    err_o        = err_q;
    tm_sec_o     = rd_bin[F_SEC];
    tm_min_o     = rd_bin[F_MIN];
    tm_hour_o    = rd_bin[F_HOUR];
    tm_mday_o    = rd_bin[F_MDAY];
    tm_mon_o     = rd_bin[F_MON] - 8'd1;
    tm_wday_o    = rd_bin[F_WDAY];
    tm_year_o    = rd_bin[F_YEAR] + 8'd100;
  end

endmodule

// File: rtl/ccs_chk.sv
module ccs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_req_o,
  input logic       xfer_done_i,
  input logic       dev_ok_o,
  input logic       dev_fault_o,
  input logic       err_o,
  input logic       time_valid_o,
  input logic       time_ready_i,
  input logic [7:0] tm_sec_o,
  input logic       rd_ready_o,
  input logic       set_ready_o
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           out_q <= 1'b0;
    else if (xfer_req_o)  out_q <= 1'b1;
    else if (xfer_done_i) out_q <= 1'b0;
  end

  // R8
  single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !xfer_req_o);

  // R2
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fault_o |=> dev_fault_o);

  // R2
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fault_o |-> !xfer_req_o);

  // R3
  ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ok_o |=> dev_ok_o);

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_ok_o && dev_fault_o));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(!dev_ok_o));

  // R6
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_valid_o && !time_ready_i) |=> (time_valid_o && $stable(tm_sec_o)));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && dev_ok_o) |-> (!rd_ready_o && !set_ready_o));

endmodule

bind clk_cal_seq ccs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_req_o  (xfer_req_o),
  .xfer_done_i (xfer_done_i),
  .dev_ok_o    (dev_ok_o),
  .dev_fault_o (dev_fault_o),
  .err_o       (err_o),
  .time_valid_o(time_valid_o),
  .time_ready_i(time_ready_i),
  .tm_sec_o    (tm_sec_o),
  .rd_ready_o  (rd_ready_o),
  .set_ready_o (set_ready_o)
);

// File: tb/clk_cal_seq_tb.sv
module clk_cal_seq_tb;
  localparam logic [3:0] A_STAT = 4'd0, A_SEC = 4'd2, A_MIN = 4'd3, A_HOUR = 4'd4,
                         A_MDAY = 4'd5, A_MON = 4'd6, A_WDAY = 4'd7, A_YEAR = 4'd8,
                         A_SNAP = 4'd14, A_COMMIT = 4'd15;
  localparam logic [7:0] PROBE = 8'h33;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rd_valid, rd_ready, set_valid, set_ready, time_valid, time_ready;
  logic [7:0] s_sec, s_min, s_hour, s_mday, s_mon, s_wday, s_year;
  logic [7:0] t_sec, t_min, t_hour, t_mday, t_mon, t_wday, t_year;
  logic dev_ok, dev_fault, err, xreq, xdone;
  logic [1:0] xkind;
  logic [3:0] xaddr;
  logic [7:0] xwdata, xrdata;

  clk_cal_seq #(
    .ADDR_W(4), .RESYNC_BITS(8), .PROBE_VAL(PROBE), .STAT_ADDR(A_STAT),
    .SEC_ADDR(A_SEC), .MIN_ADDR(A_MIN), .HOUR_ADDR(A_HOUR), .MDAY_ADDR(A_MDAY),
    .MON_ADDR(A_MON), .WDAY_ADDR(A_WDAY), .YEAR_ADDR(A_YEAR),
    .SNAP_CMD(A_SNAP), .COMMIT_CMD(A_COMMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready),
    .set_valid_i(set_valid), .set_ready_o(set_ready),
    .set_sec_i(s_sec), .set_min_i(s_min), .set_hour_i(s_hour), .set_mday_i(s_mday),
    .set_mon_i(s_mon), .set_wday_i(s_wday), .set_year_i(s_year),
    .time_valid_o(time_valid), .time_ready_i(time_ready),
    .tm_sec_o(t_sec), .tm_min_o(t_min), .tm_hour_o(t_hour), .tm_mday_o(t_mday),
    .tm_mon_o(t_mon), .tm_wday_o(t_wday), .tm_year_o(t_year),
    .dev_ok_o(dev_ok), .dev_fault_o(dev_fault), .err_o(err),
    .xfer_req_o(xreq), .xfer_kind_o(xkind), .xfer_addr_o(xaddr),
    .xfer_wdata_o(xwdata), .xfer_done_i(xdone), .xfer_rdata_i(xrdata)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] addr;
    logic [7:0] data;
    logic       cmp_addr;
    logic       cmp_data;
  } xact_t;

  xact_t exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    err_seen = 0;
  logic  corrupt = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic push(input logic [1:0] k, input logic [3:0] a, input logic [7:0] d,
                      input logic ca, input logic cd, input string tag);
    xact_t e;
    e = '{kind: k, addr: a, data: d, cmp_addr: ca, cmp_data: cd};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic push_init(input bit full);
    for (int i = 0; i < 8; i++) push(2'd0, 4'd0, 8'h00, 1'b0, 1'b0, "R1 resync bit read");
    push(2'd1, A_SEC, PROBE, 1'b1, 1'b1, "R2 probe write");
    push(2'd2, A_SEC, 8'h00, 1'b1, 1'b0, "R2 probe read");
    if (full) push(2'd1, A_STAT, 8'h00, 1'b1, 1'b1, "R3 status clear");
  endtask

  task automatic push_read();
    push(2'd3, A_SNAP, 8'h00, 1'b1, 1'b0, "R4 snapshot command");
    push(2'd2, A_SEC,  8'h00, 1'b1, 1'b0, "R4 read seconds");
    push(2'd2, A_MIN,  8'h00, 1'b1, 1'b0, "R4 read minutes");
    push(2'd2, A_HOUR, 8'h00, 1'b1, 1'b0, "R4 read hours");
    push(2'd2, A_MDAY, 8'h00, 1'b1, 1'b0, "R4 read mday");
    push(2'd2, A_MON,  8'h00, 1'b1, 1'b0, "R4 read month");
    push(2'd2, A_WDAY, 8'h00, 1'b1, 1'b0, "R4 read weekday");
    push(2'd2, A_YEAR, 8'h00, 1'b1, 1'b0, "R4 read year");
  endtask

  task automatic push_set(input int s, mi, h, d, mo, w, y);
    push(2'd1, A_SEC,  to_bcd(s),        1'b1, 1'b1, "R5 write seconds");
    push(2'd1, A_MIN,  to_bcd(mi),       1'b1, 1'b1, "R5 write minutes");
    push(2'd1, A_HOUR, to_bcd(h),        1'b1, 1'b1, "R5 write hours");
    push(2'd1, A_MDAY, to_bcd(d),        1'b1, 1'b1, "R5 write mday");
    push(2'd1, A_MON,  to_bcd(mo + 1),   1'b1, 1'b1, "R5 write month");
    push(2'd1, A_WDAY, to_bcd(w),        1'b1, 1'b1, "R5 write weekday");
    push(2'd1, A_YEAR, to_bcd(y % 100),  1'b1, 1'b1, "R5 write year");
    push(2'd3, A_COMMIT, 8'h00,          1'b1, 1'b0, "R5 commit command");
  endtask

  task automatic drive_fields(input int s, mi, h, d, mo, w, y);
    s_sec = 8'(s); s_min = 8'(mi); s_hour = 8'(h); s_mday = 8'(d);
    s_mon = 8'(mo); s_wday = 8'(w); s_year = 8'(y);
  endtask

  task automatic do_set(input int s, mi, h, d, mo, w, y);
    @(negedge clk);
    drive_fields(s, mi, h, d, mo, w, y);
    set_valid = 1'b1;
    #1;
    while (!set_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_valid = 1'b1;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wait_time(input int s, mi, h, d, mo, w, y);
    while (!time_valid) @(negedge clk);
    chk("R6 seconds", t_sec, s);
    chk("R6 minutes", t_min, mi);
    chk("R6 hours", t_hour, h);
    chk("R6 mday", t_mday, d);
    chk("R6 month zero-based", t_mon, mo);
    chk("R6 weekday", t_wday, w);
    chk("R6 year plus 100", t_year, (y % 100) + 100);
    repeat (3) @(negedge clk);
    chk("R6 valid held", time_valid, 1);
    chk("R6 seconds stable", t_sec, s);
    time_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    time_ready = 1'b0;
    chk("R6 valid drops after ready", time_valid, 0);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Serial master and device model
  logic [7:0] ram [16];
  logic [7:0] bank [16];
  logic       pend;
  int         lat;
  logic [1:0] pk;
  logic [3:0] pa;
  logic [7:0] pd;

  always @(posedge clk) begin
    xdone <= 1'b0;
    if (!rst_n) begin
      pend   <= 1'b0;
      lat    <= 0;
      xrdata <= 8'h00;
      for (int i = 0; i < 16; i++) begin ram[i] <= 8'h00; bank[i] <= 8'h00; end
    end else if (xreq) begin
      pend <= 1'b1; lat <= 2; pk <= xkind; pa <= xaddr; pd <= xwdata;
    end else if (pend) begin
      if (lat == 0) begin
        pend  <= 1'b0;
        xdone <= 1'b1;
        case (pk)
          2'd0: xrdata <= 8'hFF;
          2'd1: ram[pa] <= pd;
          2'd2: xrdata <= (corrupt && pa == A_SEC) ? 8'h32 : ram[pa];
          default: begin
            if (pa == A_SNAP)   for (int i = 0; i < 16; i++) ram[i]  <= bank[i];
            if (pa == A_COMMIT) for (int i = 0; i < 16; i++) bank[i] <= ram[i];
          end
        endcase
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // Monitor: scoreboard of transactions
  always @(negedge clk) begin
    xact_t e;
    string t;
    if (rst_n) begin
      if (err) err_seen++;
      if (xreq) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R8 unexpected transaction: actual kind %0d addr %0d, expected none", xkind, xaddr);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " kind"}, xkind, e.kind);
          if (e.cmp_addr) chk({t, " addr"}, xaddr, e.addr);
          if (e.cmp_data) chk({t, " data"}, xwdata, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    int err_before;
    rst_n = 1'b0; rd_valid = 1'b0; set_valid = 1'b0; time_ready = 1'b0;
    drive_fields(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R10 reset dev_ok", dev_ok, 0);
    chk("R10 reset dev_fault", dev_fault, 0);
    chk("R6 reset time_valid", time_valid, 0);
    chk("R7 reset err", err, 0);

    push_init(1'b1);
    rst_n = 1'b1;

    // R7: request during start-up is rejected
    @(negedge clk);
    rd_valid = 1'b1;
    #1;
    chk("R7 ready during start-up", rd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 err pulse", err, 1);
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R7 err one cycle", err, 0);

    while (!dev_ok) @(negedge clk);
    wait_drain();
    chk("R3 init complete, queue empty", exp_q.size(), 0);
    chk("R10 no fault after pass", dev_fault, 0);

    // Pattern 1
    push_set(45, 7, 23, 31, 11, 6, 124);
    do_set(45, 7, 23, 31, 11, 6, 124);
    wait_drain();
    push_read();
    do_read();
    wait_time(45, 7, 23, 31, 11, 6, 124);
    wait_drain();

    // Pattern 2: zero fields, month 0, year wrap
    push_set(0, 59, 0, 1, 0, 0, 205);
    do_set(0, 59, 0, 1, 0, 0, 205);
    wait_drain();
    push_read();
    do_read();
    wait_time(0, 59, 0, 1, 0, 0, 205);
    wait_drain();

    // R9: read wins over set when both are valid
    push_read();
    push_set(12, 34, 9, 15, 5, 3, 199);
    @(negedge clk);
    drive_fields(12, 34, 9, 15, 5, 3, 199);
    rd_valid = 1'b1;
    set_valid = 1'b1;
    #1;
    chk("R9 read ready in idle", rd_ready, 1);
    chk("R9 set held off by read", set_ready, 0);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
    chk("R9 set ready low while busy", set_ready, 0);
    wait_time(0, 59, 0, 1, 0, 0, 205);
    #1;
    while (!set_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    set_valid = 1'b0;
    wait_drain();
    push_read();
    do_read();
    wait_time(12, 34, 9, 15, 5, 3, 199);
    wait_drain();

    // R2: failed probe
    rst_n = 1'b0;
    corrupt = 1'b1;
    repeat (3) @(negedge clk);
    push_init(1'b0);
    rst_n = 1'b1;
    while (!dev_fault) @(negedge clk);
    wait_drain();
    chk("R2 fault flag", dev_fault, 1);
    chk("R2 device not ok", dev_ok, 0);
    err_before = err_seen;
    do_read();
    do_set(1, 2, 3, 4, 5, 6, 7);
    repeat (10) @(negedge clk);
    chk("R7 two rejections after fault", err_seen - err_before, 2);
    chk("R2 fault still set", dev_fault, 1);
    chk("R2 no transactions pending", exp_q.size(), 0);
    chk("R7 no result after rejection", time_valid, 0);

    summary();
    $finish;
  end
endmodule